// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs. Software configures it through a small memory-mapped bus with single-cycle write strobes and read strobes. Each channel has a power-of-two clock prescaler, a period counter and a compare threshold. An output sense bit selects the polarity. A second set of holding registers lets the period and the threshold change while the channel runs, without tearing the waveform: a held value moves into the live register only when the counter wraps.

Channels start and stop through two separate set-only registers, so that one channel can be started or stopped without a read-modify-write of the others. A status word shows which channels run. A sticky wrap-event word records every channel that completed a period. Reading the wrap-event word returns it and empties it in the same access. A single level output, `irq_o`, stays high while any wrap-event bit is set.

Top module: `pwmx_core`

## Requirements
- R1: After reset every channel is stopped, every output is low, `irq_o` is low, `bus_rdata` is zero and every register reads zero.
- R2: A write to address 0x004 starts each channel whose data bit is 1. A write to 0x008 stops each channel whose data bit is 1. Data bits at 0 leave their channel unchanged. Address 0x00C reads the run state, with bit n for channel n.
- R3: A running channel with prescaler 0 counts from 0 to period−1 and then wraps. With the sense bit clear, its output is low while the count is below the threshold and high otherwise, so each period has period−threshold high cycles.
- R4: Mode bits [3:0] hold the prescaler p, and each count lasts 2^p clock cycles. Stored values above 10 act as 10.
- R5: Mode bit 9 inverts the output of a running channel. A stopped channel drives the level of mode bit 9, and its counter rests at zero.
- R6: Channel n's registers sit at 0x200 + n·0x20: mode at +0x00, threshold at +0x04, shared holding register at +0x08, period at +0x0C and period holding register at +0x10. While the channel is stopped, writes to +0x04, +0x08 and +0x10 load the live registers at once. While it runs, writes to +0x04 and +0x0C are ignored.
- R7: While a channel runs, a value written to a holding register reaches the live register only at the next counter wrap.
- R8: Mode bit 10 steers the shared holding register at +0x08: bit clear targets the threshold, bit set targets the period.
- R9: Address 0x01C reads the wrap-event word, with bit n set when channel n wraps. The read clears the word, and `irq_o` is high while any bit is set.
- R10: Only the low 16 bits of threshold and period registers are stored. Upper bits read as zero, and mode reads back only bits [3:0], 9 and 10.
- R11: Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_o | output | 4 | Channel outputs, bit n for channel n |
| irq_o | output | 1 | High while any wrap-event bit is set |

## Verification
The properties assume that `bus_rd` and `bus_wr` are never high in the same cycle, and that every access uses a word-aligned address. One property checks the first assumption directly. The stimulus issues one bus access at a time, each strobe held for a single cycle and followed by an idle cycle. It never combines a read with a write. It waits out whole periods before sampling waveform counts or reading back values held for a wrap.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

   // global register offsets
   localparam int OFS_START = 'h04;
   localparam int OFS_STOP  = 'h08;
   localparam int OFS_RUN   = 'h0C;
   localparam int OFS_EVT   = 'h1C;

   // per-channel window offsets
   localparam logic [7:0] CO_MODE = 8'h00;
   localparam logic [7:0] CO_THR  = 8'h04;
   localparam logic [7:0] CO_HOLD = 8'h08;
   localparam logic [7:0] CO_PER  = 8'h0C;
   localparam logic [7:0] CO_PHLD = 8'h10;

   // mode word fields
   localparam int MODE_SENSE_BIT = 9;
   localparam int MODE_STEER_BIT = 10;

   typedef enum logic [2:0] {
      CR_NONE,
      CR_MODE,
      CR_THR,
      CR_HOLD,
      CR_PER,
      CR_PHLD
   } chan_reg_e;

   function automatic chan_reg_e dec_chan(input logic [7:0] ofs);
      case (ofs)
         CO_MODE: dec_chan = CR_MODE;
         CO_THR:  dec_chan = CR_THR;
         CO_HOLD: dec_chan = CR_HOLD;
         CO_PER:  dec_chan = CR_PER;
         CO_PHLD: dec_chan = CR_PHLD;
         default: dec_chan = CR_NONE;
      endcase
   endfunction

endpackage

// File: rtl/pwmx_presc.sv
module pwmx_presc #(
   parameter int PRES_W   = 4,
   parameter int MAX_PRES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [PRES_W-1:0] pres,
   output logic              tick
);
   localparam logic [PRES_W-1:0] PMAX = PRES_W'(MAX_PRES);

   logic [MAX_PRES-1:0] div_q;
   logic [PRES_W-1:0]   eff;
   logic [MAX_PRES-1:0] mask;

   assign eff  = (pres > PMAX) ? PMAX : pres;
   assign mask = ~({MAX_PRES{1'b1}} << eff);
   assign tick = run && ((div_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (!run)   div_q <= '0;
      else if (tick)   div_q <= '0;
      else             div_q <= div_q + MAX_PRES'(1);
   end
endmodule

// File: rtl/pwmx_glb.sv
module pwmx_glb #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic              wr_stop,
   input  logic              rd_evt,
   input  logic [NUM_CH-1:0] wmask,
   input  logic [NUM_CH-1:0] wrap_v,
   output logic [NUM_CH-1:0] run_q,
   output logic [NUM_CH-1:0] evt_q,
   output logic              irq_o
);
   logic [NUM_CH-1:0] set_m, clr_m;

   assign set_m = wr_start ? wmask : '0;
   assign clr_m = wr_stop  ? wmask : '0;
   assign irq_o = |evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         evt_q <= '0;
      end else begin
         run_q <= (run_q | set_m) & ~clr_m;
         evt_q <= (rd_evt ? '0 : evt_q) | wrap_v;
      end
   end
endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
   import pwmx_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PRES_W   = 4,
   parameter int MAX_PRES = 10,
   parameter int DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_en,
   input  chan_reg_e         wsel,
   input  logic [DATA_W-1:0] wdata,
   output logic              pwm_o,
   output logic              wrap_o,
   output logic              sense_o,
   output logic              steer_o,
   output logic [PRES_W-1:0] pres_o,
   output logic [CNT_W-1:0]  thr_o,
   output logic [CNT_W-1:0]  per_o,
   output logic [CNT_W-1:0]  hthr_o,
   output logic [CNT_W-1:0]  hper_o,
   output logic [CNT_W-1:0]  cnt_o
);
   logic [CNT_W-1:0] val;
   logic             tick, at_top, pend_thr, pend_per;
   logic             unused_hi;

   assign val       = wdata[CNT_W-1:0];
   assign unused_hi = ^wdata[DATA_W-1:CNT_W];

   pwmx_presc #(.PRES_W(PRES_W), .MAX_PRES(MAX_PRES)) presc_i (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .pres (pres_o),
      .tick (tick)
   );

   assign at_top = (per_o == '0) || (cnt_o >= per_o - CNT_W'(1));
   assign wrap_o = run && tick && at_top;
   assign pwm_o  = run ? ((cnt_o >= thr_o) ^ sense_o) : sense_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o    <= '0;
         thr_o    <= '0;
         per_o    <= '0;
         hthr_o   <= '0;
         hper_o   <= '0;
         pend_thr <= 1'b0;
         pend_per <= 1'b0;
         pres_o   <= '0;
         sense_o  <= 1'b0;
         steer_o  <= 1'b0;
      end else begin
         // counter
         if (!run)      cnt_o <= '0;
         else if (tick) cnt_o <= at_top ? '0 : cnt_o + CNT_W'(1);

         // wrap-time transfer of held values
         if (!run) begin
            pend_thr <= 1'b0;
            pend_per <= 1'b0;
         end else if (wrap_o) begin
            if (pend_thr) thr_o <= hthr_o;
            if (pend_per) per_o <= hper_o;
            pend_thr <= 1'b0;
            pend_per <= 1'b0;
         end

         // bus writes
         if (wr_en) begin
            case (wsel)
               CR_MODE: begin
                  pres_o  <= wdata[PRES_W-1:0];
                  sense_o <= wdata[MODE_SENSE_BIT];
                  steer_o <= wdata[MODE_STEER_BIT];
               end
               CR_THR: if (!run) thr_o <= val;
               CR_PER: if (!run) per_o <= val;
               CR_HOLD: begin
                  if (steer_o) begin
                     hper_o <= val;
                     if (!run) per_o <= val;
                     else      pend_per <= 1'b1;
                  end else begin
                     hthr_o <= val;
                     if (!run) thr_o <= val;
                     else      pend_thr <= 1'b1;
                  end
               end
               CR_PHLD: begin
                  hper_o <= val;
                  if (!run) per_o <= val;
                  else      pend_per <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pwmx_core.sv
module pwmx_core
   import pwmx_pkg::*;
#(
   parameter int NUM_CH       = 4,
   parameter int CNT_W        = 16,
   parameter int PRES_W       = 4,
   parameter int MAX_PRES     = 10,
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 32,
   parameter int CH_BASE      = 'h200,
   parameter int CH_STRIDE_LG = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_o,
   output logic              irq_o
);
   localparam int CH_IW = $clog2(NUM_CH);
   localparam logic [ADDR_W-1:0] CH_LO = ADDR_W'(CH_BASE);
   localparam logic [ADDR_W-1:0] CH_HI = ADDR_W'(CH_BASE + (NUM_CH << CH_STRIDE_LG));

   // elaboration-time parameter checks
   if (NUM_CH < 2)                       begin : g_e0 $error("NUM_CH must be at least 2"); end
   if (DATA_W <= CNT_W)                  begin : g_e1 $error("DATA_W must exceed CNT_W"); end
   if (DATA_W <= MODE_STEER_BIT)         begin : g_e2 $error("DATA_W too narrow for mode word"); end
   if (MAX_PRES < 1)                     begin : g_e3 $error("MAX_PRES must be positive"); end
   if (MAX_PRES >= (1 << PRES_W))        begin : g_e4 $error("PRES_W cannot hold MAX_PRES"); end
   if (CH_STRIDE_LG < 5 || CH_STRIDE_LG > 8) begin : g_e5 $error("stride out of range"); end
   if (CH_BASE + (NUM_CH << CH_STRIDE_LG) >= (1 << ADDR_W)) begin : g_e6 $error("address map overflows ADDR_W"); end

   logic [NUM_CH-1:0]        run_q, evt_q, wrap_v, sense_v, steer_v;
   logic [NUM_CH*CNT_W-1:0]  thr_f, per_f, hthr_f, hper_f, cnt_f;
   logic [NUM_CH*PRES_W-1:0] pres_f;

   logic              in_ch, rd_evt;
   logic [ADDR_W-1:0] rel, ch_idx;
   logic [CH_IW-1:0]  ci;
   chan_reg_e         csel;
   logic [DATA_W-1:0] rd_mux;

   assign in_ch  = (bus_addr >= CH_LO) && (bus_addr < CH_HI);
   assign rel    = bus_addr - CH_LO;
   assign ch_idx = rel >> CH_STRIDE_LG;
   assign ci     = ch_idx[CH_IW-1:0];
   assign csel   = in_ch ? dec_chan(8'(rel[CH_STRIDE_LG-1:0])) : CR_NONE;
   assign rd_evt = bus_rd && (bus_addr == ADDR_W'(OFS_EVT));

   pwmx_glb #(.NUM_CH(NUM_CH)) glb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_start(bus_wr && (bus_addr == ADDR_W'(OFS_START))),
      .wr_stop (bus_wr && (bus_addr == ADDR_W'(OFS_STOP))),
      .rd_evt  (rd_evt),
      .wmask   (bus_wdata[NUM_CH-1:0]),
      .wrap_v  (wrap_v),
      .run_q   (run_q),
      .evt_q   (evt_q),
      .irq_o   (irq_o)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pwmx_chan #(
         .CNT_W(CNT_W), .PRES_W(PRES_W), .MAX_PRES(MAX_PRES), .DATA_W(DATA_W)
      ) chan_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run_q[g]),
         .wr_en  (bus_wr && in_ch && (ch_idx == ADDR_W'(g))),
         .wsel   (csel),
         .wdata  (bus_wdata),
         .pwm_o  (pwm_o[g]),
         .wrap_o (wrap_v[g]),
         .sense_o(sense_v[g]),
         .steer_o(steer_v[g]),
         .pres_o (pres_f[g*PRES_W +: PRES_W]),
         .thr_o  (thr_f[g*CNT_W +: CNT_W]),
         .per_o  (per_f[g*CNT_W +: CNT_W]),
         .hthr_o (hthr_f[g*CNT_W +: CNT_W]),
         .hper_o (hper_f[g*CNT_W +: CNT_W]),
         .cnt_o  (cnt_f[g*CNT_W +: CNT_W])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (in_ch) begin
         case (csel)
            CR_MODE: begin
               rd_mux[PRES_W-1:0]     = pres_f[ci*PRES_W +: PRES_W];
               rd_mux[MODE_SENSE_BIT] = sense_v[ci];
               rd_mux[MODE_STEER_BIT] = steer_v[ci];
            end
            CR_THR:  rd_mux = DATA_W'(thr_f[ci*CNT_W +: CNT_W]);
            CR_HOLD: rd_mux = steer_v[ci] ? DATA_W'(hper_f[ci*CNT_W +: CNT_W])
                                          : DATA_W'(hthr_f[ci*CNT_W +: CNT_W]);
            CR_PER:  rd_mux = DATA_W'(per_f[ci*CNT_W +: CNT_W]);
            CR_PHLD: rd_mux = DATA_W'(hper_f[ci*CNT_W +: CNT_W]);
            default: rd_mux = '0;
         endcase
      end else if (bus_addr == ADDR_W'(OFS_RUN)) begin
         rd_mux = DATA_W'(run_q);
      end else if (bus_addr == ADDR_W'(OFS_EVT)) begin
         rd_mux = DATA_W'(evt_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end
endmodule

// File: rtl/pwmx_chk.sv
module pwmx_chk
   import pwmx_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bus_wr,
   input logic                    bus_rd,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [DATA_W-1:0]       bus_wdata,
   input logic [NUM_CH-1:0]       pwm_o,
   input logic [NUM_CH-1:0]       run_q,
   input logic [NUM_CH-1:0]       evt_q,
   input logic [NUM_CH-1:0]       wrap_v,
   input logic [NUM_CH-1:0]       sense_v,
   input logic [NUM_CH*CNT_W-1:0] cnt_f,
   input logic [NUM_CH*CNT_W-1:0] per_f
);
   logic [NUM_CH-1:0] wm;
   assign wm = bus_wdata[NUM_CH-1:0];

   AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd)); // R11

   AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_START)) |=> ((run_q & $past(wm)) == $past(wm))); // R2

   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_STOP)) |=> ((run_q & $past(wm)) == '0)); // R2

   AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(OFS_EVT)) |=> (evt_q == $past(wrap_v))); // R9

   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (((pwm_o ^ sense_v) & ~run_q) == '0)); // R5

   for (genvar i = 0; i < NUM_CH; i++) begin : g_c
      logic [CNT_W-1:0] c, p;
      assign c = cnt_f[i*CNT_W +: CNT_W];
      assign p = per_f[i*CNT_W +: CNT_W];

      AST_CNT_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_q[i] && $past(!run_q[i])) |-> (c == '0)); // R5

      AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         run_q[i] |-> ((p == '0) ? (c == '0) : (c < p))); // R3

      AST_WRAP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
         wrap_v[i] |-> run_q[i]); // R9
   end
endmodule

bind pwmx_core pwmx_chk #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .pwm_o    (pwm_o),
   .run_q    (run_q),
   .evt_q    (evt_q),
   .wrap_v   (wrap_v),
   .sense_v  (sense_v),
   .cnt_f    (cnt_f),
   .per_f    (per_f)
);

// File: tb/pwmx_core_tb_top.sv
`timescale 1ns/1ps
module pwmx_core_tb_top;
   typedef struct {
      logic [31:0] exp;
      logic [31:0] msk;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_chk = 0;
   int          n_err = 0;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, rd_d = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_o;
   logic        irq_o;

   always #2 clk = ~clk;

   pwmx_core dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_o(pwm_o), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // driver: queues the expected item, then issues the read
   task automatic rd(input logic [11:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
      exp_t it;
      it.exp = e; it.msk = m; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic count_high(input int idx, input int n, output int hi);
      hi = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_o[idx]) hi++;
      end
   endtask

   // monitor: compares registered read data one edge after the strobe
   always @(posedge clk) rd_d <= bus_rd;
   always @(negedge clk) begin
      exp_t e;
      if (rd_d) begin
         if (sb_q.size() == 0) begin
            check("R11 read without expectation", bus_rdata, 32'hDEAD_BEEF);
         end else begin
            e = sb_q.pop_front();
            check(e.tag, bus_rdata & e.msk, e.exp & e.msk);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int hi;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 outputs low", {28'd0, pwm_o}, 32'd0);
      check("R1 irq low", {31'd0, irq_o}, 32'd0);
      check("R1 rdata zero", bus_rdata, 32'd0);
      rd(12'h00C, 32'd0, 32'hFFFF_FFFF, "R1 run word zero");
      rd(12'h20C, 32'd0, 32'hFFFF_FFFF, "R1 period zero");

      // R10: field widths on channel 3 (stopped)
      wr(12'h26C, 32'hABC1_2345);
      rd(12'h26C, 32'h0000_2345, 32'hFFFF_FFFF, "R10 period upper bits dropped");
      wr(12'h260, 32'hFFFF_FFFF);
      rd(12'h260, 32'h0000_060F, 32'hFFFF_FFFF, "R10 mode fields only");
      wr(12'h260, 32'h0);

      // R2: set-only start / stop
      wr(12'h004, 32'h5);
      rd(12'h00C, 32'h5, 32'hFFFF_FFFF, "R2 start bits 0 and 2");
      wr(12'h004, 32'h0);
      rd(12'h00C, 32'h5, 32'hFFFF_FFFF, "R2 zero start no effect");
      wr(12'h008, 32'h1);
      rd(12'h00C, 32'h4, 32'hFFFF_FFFF, "R2 stop bit 0");
      wr(12'h008, 32'h0);
      rd(12'h00C, 32'h4, 32'hFFFF_FFFF, "R2 zero stop no effect");
      wr(12'h008, 32'hF);

      // R3 / R5 waveform on channel 0
      wr(12'h200, 32'h0);
      wr(12'h204, 32'd3);
      wr(12'h20C, 32'd10);
      rd(12'h204, 32'd3, 32'hFFFF_FFFF, "R6 direct threshold while stopped");
      wr(12'h004, 32'h1);
      repeat (5) @(negedge clk);
      count_high(0, 100, hi);
      check("R3 high cycles 10/3", hi, 70);
      wr(12'h200, 32'h200);
      repeat (3) @(negedge clk);
      count_high(0, 100, hi);
      check("R5 inverted high cycles", hi, 30);
      wr(12'h008, 32'h1);
      repeat (2) @(negedge clk);
      check("R5 stopped output follows sense 1", {31'd0, pwm_o[0]}, 32'd1);
      wr(12'h200, 32'h0);
      repeat (2) @(negedge clk);
      check("R5 stopped output follows sense 0", {31'd0, pwm_o[0]}, 32'd0);

      // R4 prescaler
      wr(12'h200, 32'h2);
      wr(12'h204, 32'd1);
      wr(12'h20C, 32'd4);
      wr(12'h004, 32'h1);
      repeat (5) @(negedge clk);
      count_high(0, 160, hi);
      check("R4 prescaler 2", hi, 120);
      wr(12'h008, 32'h1);
      wr(12'h200, 32'hF);
      wr(12'h20C, 32'd2);
      wr(12'h004, 32'h1);
      repeat (5) @(negedge clk);
      count_high(0, 2048, hi);
      check("R4 prescaler 15 acts as 10", hi, 1024);
      wr(12'h008, 32'h1);

      // R6 / R7 / R8 on channel 1
      wr(12'h224, 32'd5);
      wr(12'h22C, 32'd20);
      wr(12'h004, 32'h2);
      wr(12'h228, 32'd15);
      rd(12'h224, 32'd5, 32'hFFFF_FFFF, "R7 held threshold not yet live");
      repeat (30) @(negedge clk);
      rd(12'h224, 32'd15, 32'hFFFF_FFFF, "R7 threshold live after wrap");
      wr(12'h224, 32'd2);
      rd(12'h224, 32'd15, 32'hFFFF_FFFF, "R6 threshold write ignored while running");
      wr(12'h22C, 32'd9);
      rd(12'h22C, 32'd20, 32'hFFFF_FFFF, "R6 period write ignored while running");
      wr(12'h220, 32'h400);
      wr(12'h228, 32'd8);
      repeat (30) @(negedge clk);
      rd(12'h22C, 32'd8, 32'hFFFF_FFFF, "R8 shared holding steered to period");
      rd(12'h224, 32'd15, 32'hFFFF_FFFF, "R8 threshold untouched by steered write");

      // R9 wrap events on channel 2
      wr(12'h008, 32'hF);
      rd(12'h01C, 32'd0, 32'd0, "R9 flush events");
      @(negedge clk);
      check("R9 irq low after flush", {31'd0, irq_o}, 32'd0);
      wr(12'h240, 32'h0);
      wr(12'h244, 32'd2);
      wr(12'h24C, 32'd5);
      wr(12'h004, 32'h4);
      repeat (20) @(negedge clk);
      check("R9 irq high after wrap", {31'd0, irq_o}, 32'd1);
      wr(12'h008, 32'h4);
      rd(12'h01C, 32'h4, 32'hFFFF_FFFF, "R9 event bit 2");
      rd(12'h01C, 32'h0, 32'hFFFF_FFFF, "R9 cleared by read");
      @(negedge clk);
      check("R9 irq low after clear", {31'd0, irq_o}, 32'd0);

      repeat (4) @(negedge clk);
      check("R11 scoreboard drained", sb_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule